// File: doc/BRIEF.md
# Floating Compare Unit with Reserved-Operand Handling

This block takes two 64-bit floating-point operands in register format and a two-bit function code. It answers one of three ordering questions: equal, less-than or less-or-equal. The format has no NaNs. An operand whose exponent field is zero is valid only when all 64 bits are zero. Any other zero-exponent pattern is a reserved operand. A reserved operand raises the invalid-operand trap and forces the internal ordering to "greater", so every predicate then answers false.

Ordering comes straight from the packed bit patterns, with no unpacking. Identical patterns are equal. When the signs differ, the negative operand is smaller. When the signs match, the unsigned comparison of the patterns is inverted if the shared sign is negative. The answer is registered. It appears one clock after the input strobe, together with an output-valid pulse and the trap flag.

Top module: `fcmp_unit`

## Requirements
- R1: An operand with exponent field bits 62:52 all zero and any other bit set is reserved. A compare with either operand reserved sets trap_o in the output cycle. Both a negative zero (only bit 63 set) and a pattern with only bit 0 set count as reserved.
- R2: The all-zero pattern is a true zero and is not reserved. trap_o is high only in a cycle where res_valid_o is high, and only when an operand of that compare was reserved.
- R3: When either operand is reserved, the ordering is "greater", and the result is false for every function code.
- R4: Two non-reserved operands with identical 64-bit patterns compare equal.
- R5: Between non-reserved operands whose sign bits (bit 63) differ, the operand with bit 63 set is the smaller.
- R6: Between non-reserved operands with equal sign bits, the first operand is less exactly when (unsigned first < unsigned second) XOR sign holds, given that the patterns differ. Otherwise it is greater.
- R7: Function code 2'b00 answers "equal", 2'b01 answers "less", 2'b10 answers "less or equal", and 2'b11 always answers false.
- R8: A true result is 64'h4000_0000_0000_0000 (only bit 62 set). A false result is all zeros.
- R9: res_valid_o pulses exactly one clock after each cycle with valid_i high, and at no other time.
- R10: While rst is high, res_valid_o, trap_o and result_o are all zero.
- R11: In a cycle without valid_i, result_o keeps its previous value and trap_o is low.

Ports, in the order of the top module's port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Compare request strobe |
| fn_i | input | 2 | Function code (00 equal, 01 less, 10 less-or-equal, 11 none) |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| res_valid_o | output | 1 | Result valid, one clock after valid_i |
| result_o | output | 64 | True (bit 62 only) or false (zero) |
| trap_o | output | 1 | Invalid-operand trap for the reported compare |

## Verification
The hardest situation to reach is a reserved operand. A uniformly drawn 64-bit word has a zero exponent field only once in 2048 draws. The same draws also almost never give identical patterns, or operands that share a magnitude and differ only in sign. The stimulus therefore clears the exponent field on a share of the random operands. It reuses the first operand as the second, or flips only its sign bit, on other shares. Directed cases cover negative zero, a single low bit, and two reserved operands at once. Every one of these cases is run under all four function codes.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int unsigned FP_W     = 64;
  localparam int unsigned SIGN_POS = FP_W - 1;
  localparam int unsigned EXP_HI   = 62;
  localparam int unsigned EXP_LO   = 52;
  localparam int unsigned TRUE_POS = 62;

  typedef enum logic [1:0] {
    ORD_LESS    = 2'b00,
    ORD_EQUAL   = 2'b01,
    ORD_GREATER = 2'b10
  } order_e;

  typedef enum logic [1:0] {
    FN_EQ   = 2'b00,
    FN_LT   = 2'b01,
    FN_LE   = 2'b10,
    FN_NONE = 2'b11
  } cmp_fn_e;

  // Exponent field empty
  function automatic logic exp_field_zero(input logic [FP_W-1:0] op);
    return op[EXP_HI:EXP_LO] == '0;
  endfunction

  // Zero exponent with any other bit set
  function automatic logic pattern_reserved(input logic [FP_W-1:0] op);
    return exp_field_zero(op) && (op != '0);
  endfunction

  // Ordering of two legal patterns
  function automatic order_e order_legal(input logic [FP_W-1:0] a,
                                         input logic [FP_W-1:0] b);
    logic sa, sb;
    sa = a[SIGN_POS];
    sb = b[SIGN_POS];
    if (a == b)       return ORD_EQUAL;
    else if (sa != sb) return sa ? ORD_LESS : ORD_GREATER;
    else if ((a < b) ^ sa) return ORD_LESS;
    else              return ORD_GREATER;
  endfunction

  // Does the ordering satisfy the requested predicate
  function automatic logic predicate_hit(input cmp_fn_e fn, input order_e ord);
    case (fn)
      FN_EQ:   return ord == ORD_EQUAL;
      FN_LT:   return ord == ORD_LESS;
      FN_LE:   return (ord == ORD_LESS) || (ord == ORD_EQUAL);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fcmp_operand_check.sv
module fcmp_operand_check
  import fcmp_pkg::*;
#(
  parameter int unsigned W = FP_W
) (
  input  logic [W-1:0] op_i,
  output logic         reserved_o
);

  logic exp_empty;
  logic any_bit;

  assign exp_empty  = exp_field_zero(op_i);
  assign any_bit    = |op_i;
  assign reserved_o = pattern_reserved(op_i);

  // R2: the all-zero word is never flagged
  always_comb begin
    if (!any_bit) a_r2_zero_legal: assert (!reserved_o);
    if (!exp_empty) a_r1_needs_zero_exp: assert (!reserved_o);
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int unsigned W = FP_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         any_reserved_i,
  output order_e       ord_o
);

  logic signs_differ;
  logic patterns_match;
  order_e legal_ord;

  assign signs_differ   = a_i[W-1] ^ b_i[W-1];
  assign patterns_match = (a_i == b_i);
  assign legal_ord      = order_legal(a_i, b_i);
  assign ord_o          = any_reserved_i ? ORD_GREATER : legal_ord;

  always_comb begin
    // R3: reserved forces greater
    if (any_reserved_i) a_r3_reserved_greater: assert (ord_o == ORD_GREATER);
    // R4: identical legal patterns are equal
    if (!any_reserved_i && patterns_match) a_r4_match_equal: assert (ord_o == ORD_EQUAL);
    // R5: negative side is smaller when signs differ
    if (!any_reserved_i && signs_differ)
      a_r5_sign_split: assert (ord_o == (a_i[W-1] ? ORD_LESS : ORD_GREATER));
  end

endmodule

// File: rtl/fcmp_predicate.sv
module fcmp_predicate
  import fcmp_pkg::*;
(
  input  cmp_fn_e fn_i,
  input  order_e  ord_i,
  output logic    hit_o
);

  assign hit_o = predicate_hit(fn_i, ord_i);

  always_comb begin
    // R7: no function code accepts a greater ordering; code 11 accepts nothing
    if (ord_i == ORD_GREATER) a_r7_greater_false: assert (!hit_o);
    if (fn_i == FN_NONE) a_r7_none_false: assert (!hit_o);
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int unsigned W       = FP_W,
  parameter int unsigned TRUE_AT = TRUE_POS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [1:0]   fn_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         res_valid_o,
  output logic [W-1:0] result_o,
  output logic         trap_o
);

  localparam int unsigned NOPS = 2;
  localparam logic [W-1:0] TRUE_WORD = W'(1) << TRUE_AT;

  logic [NOPS-1:0][W-1:0] ops;
  logic [NOPS-1:0]        op_reserved;
  logic                   any_reserved;
  order_e                 ord;
  logic                   hit;
  cmp_fn_e                fn;

  assign ops[0] = opa_i;
  assign ops[1] = opb_i;
  assign fn     = cmp_fn_e'(fn_i);

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_chk
    fcmp_operand_check #(.W(W)) u_chk (
      .op_i       (ops[gi]),
      .reserved_o (op_reserved[gi])
    );
  end

  assign any_reserved = |op_reserved;

  fcmp_order #(.W(W)) u_order (
    .a_i            (opa_i),
    .b_i            (opb_i),
    .any_reserved_i (any_reserved),
    .ord_o          (ord)
  );

  fcmp_predicate u_pred (
    .fn_i  (fn),
    .ord_i (ord),
    .hit_o (hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      trap_o      <= 1'b0;
      result_o    <= '0;
    end else begin
      res_valid_o <= valid_i;
      trap_o      <= valid_i && any_reserved;
      if (valid_i) result_o <= hit ? TRUE_WORD : '0;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> res_valid_o);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> !res_valid_o);
  a_r8_two_values: assert property (@(posedge clk) disable iff (rst)
    (result_o == '0) || (result_o == TRUE_WORD));
  a_r2_trap_needs_valid: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> res_valid_o);
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> ($stable(result_o) && !trap_o));
  a_r3_reserved_false: assert property (@(posedge clk) disable iff (rst)
    (valid_i && any_reserved) |=> (trap_o && result_o == '0));
  a_r1_trap_source: assert property (@(posedge clk) disable iff (rst)
    (valid_i && !any_reserved) |=> !trap_o);

endmodule

// File: tb/tb_fcmp_unit.sv
module tb_fcmp_unit;

  localparam logic [63:0] T_WORD = 64'h4000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [1:0]  fn_i;
  logic [63:0] opa_i, opb_i;
  logic        res_valid_o;
  logic [63:0] result_o;
  logic        trap_o;

  int n_run  = 0;
  int n_fail = 0;
  logic        exp_v;
  logic [63:0] exp_r;
  logic        exp_t;

  always #4 clk = ~clk;

  fcmp_unit dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .fn_i(fn_i),
    .opa_i(opa_i), .opb_i(opb_i),
    .res_valid_o(res_valid_o), .result_o(result_o), .trap_o(trap_o)
  );

  function automatic bit ref_bad(input logic [63:0] x);
    return (x[62:52] == 11'd0) && (x != 64'd0);
  endfunction

  // Map each legal word to an unsigned key whose order is the numeric order
  function automatic logic [63:0] ref_key(input logic [63:0] x);
    return x[63] ? ~x : (x | 64'h8000_0000_0000_0000);
  endfunction

  function automatic string ref_tag(input logic [63:0] a, input logic [63:0] b);
    if (ref_bad(a) || ref_bad(b)) return "R3";
    if (a == b) return "R4";
    if (a[63] != b[63]) return "R5";
    return "R6";
  endfunction

  // lt: -1 less, 0 equal, 1 greater
  function automatic logic [63:0] ref_result(input logic [1:0] f,
                                             input logic [63:0] a,
                                             input logic [63:0] b);
    int rel;
    bit yes;
    if (ref_bad(a) || ref_bad(b)) rel = 1;
    else if (ref_key(a) < ref_key(b)) rel = -1;
    else if (ref_key(a) == ref_key(b)) rel = 0;
    else rel = 1;
    case (f)
      2'b00: yes = (rel == 0);
      2'b01: yes = (rel < 0);
      2'b10: yes = (rel <= 0);
      default: yes = 1'b0;
    endcase
    return yes ? T_WORD : 64'd0;
  endfunction

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] f,
                      input logic [63:0] a, input logic [63:0] b);
    string tag;
    valid_i = v; fn_i = f; opa_i = a; opb_i = b;
    if (v) begin
      exp_v = 1'b1;
      exp_t = ref_bad(a) || ref_bad(b);
      exp_r = ref_result(f, a, b);
      tag = (f == 2'b11) ? "R7" : ref_tag(a, b);
    end else begin
      exp_v = 1'b0;
      exp_t = 1'b0;
      tag = "R11";
    end
    @(negedge clk);
    check("R9", {63'd0, res_valid_o}, {63'd0, exp_v}, "valid");
    check(exp_t ? "R1" : "R2", {63'd0, trap_o}, {63'd0, exp_t}, "trap");
    check(tag, result_o, exp_r, "result");
    if (result_o != 64'd0) check("R8", result_o, T_WORD, "true word");
  endtask

  task automatic all_fn(input logic [63:0] a, input logic [63:0] b);
    for (int f = 0; f < 4; f++) step(1'b1, f[1:0], a, b);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; valid_i = 1'b1; fn_i = 2'b00; opa_i = '0; opb_i = '0;
    exp_r = '0;
    repeat (3) @(negedge clk);
    // R10: reset holds outputs at zero even with a request present
    check("R10", {63'd0, res_valid_o}, 64'd0, "valid in reset");
    check("R10", {63'd0, trap_o}, 64'd0, "trap in reset");
    check("R10", result_o, 64'd0, "result in reset");
    rst = 1'b0;
    valid_i = 1'b0;
    @(negedge clk);

    // R4 equal patterns, R2 all-zero legal
    all_fn(64'h0, 64'h0);
    all_fn(64'h4010_0000_0000_0000, 64'h4010_0000_0000_0000);
    // R5 sign split
    all_fn(64'hC010_0000_0000_0000, 64'h0000_0000_0000_0000);
    all_fn(64'h4010_0000_0000_0000, 64'hC000_0000_0000_0001);
    // R6 same sign, both orders
    all_fn(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000);
    all_fn(64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000);
    all_fn(64'hBFF0_0000_0000_0000, 64'hC000_0000_0000_0000);
    // R1 / R3 reserved shapes
    all_fn(64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000);
    all_fn(64'h3FF0_0000_0000_0000, 64'h0000_0000_0000_0001);
    all_fn(64'h800F_FFFF_FFFF_FFFF, 64'h800F_FFFF_FFFF_FFFF);
    all_fn(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000);

    // R11: hold after a true result, then after a false one
    step(1'b1, 2'b00, 64'h4000_0000_0000_0000, 64'h4000_0000_0000_0000);
    step(1'b0, 2'b01, 64'h8000_0000_0000_0000, 64'h1);
    step(1'b0, 2'b10, 64'h0, 64'h0);
    step(1'b1, 2'b11, 64'h0, 64'h0);
    step(1'b0, 2'b00, 64'h0, 64'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      int pick;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      pick = $urandom_range(0, 9);
      if (pick == 0) a[62:52] = '0;
      if (pick == 1) b[62:52] = '0;
      if (pick == 2) b = a;
      if (pick == 3) b = {~a[63], a[62:0]};
      if (pick == 4) b = {a[63], b[62:0]};
      if (pick == 5) begin a[62:52] = '0; b = a; end
      step($urandom_range(0, 7) != 0, 2'($urandom_range(0, 3)), a, b);
    end

    step(1'b0, 2'b00, 64'h0, 64'h0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule